// File: doc/BRIEF.md
# Two-Parallel Unfolded FIR Filter

This block is a low-pass FIR filter that turns out two filtered samples for every core step. It is built from a single-rate transposed filter, where each new sample goes to every multiplier at once and the delay registers sit between the adders. That filter is unfolded by a factor of two. Unfolding makes two copies of each adder node. Copy 1 of node k adds the odd sample's product to copy 0 of node k+1 with no register between them. Copy 0 of node k adds the even sample's product to a registered value of copy 1 of node k+1. The tap count and the coefficient set are parameters, and the block supports 2, 4 and 11 taps.

All logic runs on the one system clock, and two clock-enable pulses set the rates. The slot enable fires once for every input sample. The pair enable fires on every second slot, so the core runs at half the input sample rate. A two-state pairing machine forms the even/odd pairs. In state COLLECT_EVEN a slot strobe stores the incoming sample as x(2k) and moves the machine to COLLECT_ODD. In COLLECT_ODD the next slot strobe completes the pair with x(2k+1), issues the pair to the core and moves the machine back to COLLECT_EVEN. The core then updates its delay registers and presents y(2k) and y(2k+1) together under one valid strobe.

Top module: `fir2_unfolded_top`

## Requirements
- R1: `slot_tick` is high for exactly one system cycle, once every FAST_DIV system cycles. `sample_in` is captured at the rising edge where `slot_tick` is high.
- R2: After reset, the first captured sample is x(0), the even member of a pair. Captured samples then alternate even, odd, even.
- R3: The pair enable is high only on the slot in which the pairing machine is in COLLECT_ODD, so it falls on every second slot.
- R4: For every pair k, `y_even` corresponds to y(2k) and `y_odd` to y(2k+1), where y(n) = sum over j of h(j)*x(n-j). Any sample captured before the last reset counts as zero.
- R5: Coefficient h(j) occupies bits [j*COEF_W +: COEF_W] of COEFS, and h(0) weights the newest sample. The filter is exact for NTAPS of 2, 4 and 11.
- R6: Products and sums keep full signed precision. Each output is the sum shifted arithmetically right by SHIFT, truncated to its low OUT_W bits, and read as signed two's complement.
- R7: `y_valid` is a one-cycle pulse. It is high in the second system cycle after the slot cycle that captured the odd sample.
- R8: `y_even` and `y_odd` change only in a cycle where `y_valid` is high, and they hold their values otherwise.
- R9: While reset is low, `y_valid`, `slot_tick`, `y_even` and `y_odd` are zero. Reset clears the delay registers and returns the pairing machine to COLLECT_EVEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | SAMPLE_W | Serial signed sample, captured at each slot strobe |
| slot_tick | output | 1 | Slot enable; marks the cycle in which `sample_in` is taken |
| y_even | output | OUT_W | Filtered output y(2k) |
| y_odd | output | OUT_W | Filtered output y(2k+1) |
| y_valid | output | 1 | One-cycle strobe for a new output pair |

## Verification
The bench drives impulses on both even and odd positions. A filter with swapped register/no-register edges would put those impulses on the wrong output lane or in the wrong pair. Coefficient sets that are not symmetric expose a reversed tap order, and the full-scale steps, the alternating extremes and a sweep through every sample code expose lost precision and wrong sign handling in the shift. A reset in the middle of the run shows whether stale delay contents or a stale pairing phase survive reset: the first pairs afterwards would be shifted or would still carry the old history. The bench also times every valid strobe against the odd slot that produced it, so a late pulse, an early pulse or a pulse that lasts two cycles shows up.

// File: rtl/fir2_pkg.sv
package fir2_pkg;
    typedef enum logic {
        COLLECT_EVEN = 1'b0,
        COLLECT_ODD  = 1'b1
    } pair_state_t;
endpackage

// File: rtl/fir2_tick_gen.sv
module fir2_tick_gen #(
    parameter int FAST_DIV = 42
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_ce,
    output logic pair_ce
);
    localparam int DW = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(FAST_DIV - 1);

    logic [DW-1:0] cnt;
    logic          odd_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            odd_slot <= 1'b0;
            slot_ce  <= 1'b0;
            pair_ce  <= 1'b0;
        end else begin
            slot_ce <= (cnt == LAST);
            pair_ce <= (cnt == LAST) && odd_slot;
            if (cnt == LAST) begin
                cnt      <= '0;
                odd_slot <= ~odd_slot;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1: the slot enable is never two cycles wide
    p_slot_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_ce |=> !slot_ce);
endmodule

// File: rtl/fir2_s2p.sv
module fir2_s2p
    import fir2_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       slot_ce,
    input  logic                       pair_ce,
    input  logic signed [SAMPLE_W-1:0] din,
    output logic signed [SAMPLE_W-1:0] pair_even,
    output logic signed [SAMPLE_W-1:0] pair_odd,
    output logic                       pair_ready
);
    pair_state_t state, state_nx;
    logic signed [SAMPLE_W-1:0] hold_even;

    always_comb begin
        state_nx = state;
        unique case (state)
            COLLECT_EVEN: if (slot_ce) state_nx = COLLECT_ODD;
            COLLECT_ODD:  if (slot_ce) state_nx = COLLECT_EVEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= COLLECT_EVEN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_even  <= '0;
            pair_even  <= '0;
            pair_odd   <= '0;
            pair_ready <= 1'b0;
        end else begin
            pair_ready <= pair_ce;
            if (slot_ce && state == COLLECT_EVEN) hold_even <= din;
            if (pair_ce) begin
                pair_even <= hold_even;
                pair_odd  <= din;
            end
        end
    end

    // R3: the pair enable from the tick generator lands only on the odd slot
    p_pair_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ce |-> (slot_ce && state == COLLECT_ODD));
    // R7: a completed pair is handed on in the following cycle
    p_ready_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ce |=> pair_ready);
endmodule

// File: rtl/fir2_unfolded_core.sv
module fir2_unfolded_core #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int NTAPS    = 4,
    parameter logic [NTAPS*COEF_W-1:0] COEFS = '0,
    parameter int OUT_W    = 16,
    parameter int SHIFT    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pair_ready,
    input  logic signed [SAMPLE_W-1:0] pair_even,
    input  logic signed [SAMPLE_W-1:0] pair_odd,
    output logic signed [OUT_W-1:0]    y_even,
    output logic signed [OUT_W-1:0]    y_odd,
    output logic                       y_valid
);
    localparam int PW = SAMPLE_W + COEF_W;
    localparam int FW = PW + $clog2(NTAPS) + 1;

    logic signed [FW-1:0] p0 [NTAPS];
    logic signed [FW-1:0] p1 [NTAPS];
    logic signed [FW-1:0] s0 [NTAPS];
    logic signed [FW-1:0] s1 [NTAPS];
    logic signed [FW-1:0] dly [NTAPS-1];
    logic signed [FW-1:0] sh0, sh1;

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        logic signed [COEF_W-1:0] h;
        logic signed [PW-1:0]     m0, m1;
        assign h  = COEFS[k*COEF_W +: COEF_W];
        assign m0 = h * pair_even;
        assign m1 = h * pair_odd;
        assign p0[k] = {{(FW-PW){m0[PW-1]}}, m0};
        assign p1[k] = {{(FW-PW){m1[PW-1]}}, m1};
        if (k == NTAPS - 1) begin : g_end
            assign s0[k] = p0[k];
            assign s1[k] = p1[k];
        end else begin : g_mid
            // even copy: registered edge from the odd copy one node down
            assign s0[k] = p0[k] + dly[k];
            // odd copy: unregistered edge from the even copy one node down
            assign s1[k] = p1[k] + s0[k+1];
        end
    end

    assign sh0 = s0[0] >>> SHIFT;
    assign sh1 = s1[0] >>> SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS - 1; k++) dly[k] <= '0;
            y_even  <= '0;
            y_odd   <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= pair_ready;
            if (pair_ready) begin
                for (int k = 0; k < NTAPS - 1; k++) dly[k] <= s1[k+1];
                y_even <= sh0[OUT_W-1:0];
                y_odd  <= sh1[OUT_W-1:0];
            end
        end
    end

    // R8: outputs move only together with the valid strobe
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (y_even != $past(y_even) || y_odd != $past(y_odd)) |-> y_valid);
endmodule

// File: rtl/fir2_unfolded_top.sv
module fir2_unfolded_top #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int NTAPS    = 4,
    parameter logic [NTAPS*COEF_W-1:0] COEFS = {8'sd18, 8'sd45, 8'sd37, 8'sd12},
    parameter int OUT_W    = 16,
    parameter int SHIFT    = 4,
    parameter int FAST_DIV = 42
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic                       slot_tick,
    output logic signed [OUT_W-1:0]    y_even,
    output logic signed [OUT_W-1:0]    y_odd,
    output logic                       y_valid
);
    logic pair_ce;
    logic pair_ready;
    logic signed [SAMPLE_W-1:0] pair_even, pair_odd;

    fir2_tick_gen #(.FAST_DIV(FAST_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_ce (slot_tick),
        .pair_ce (pair_ce)
    );

    fir2_s2p #(.SAMPLE_W(SAMPLE_W)) u_s2p (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_ce    (slot_tick),
        .pair_ce    (pair_ce),
        .din        (sample_in),
        .pair_even  (pair_even),
        .pair_odd   (pair_odd),
        .pair_ready (pair_ready)
    );

    fir2_unfolded_core #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .NTAPS    (NTAPS),
        .COEFS    (COEFS),
        .OUT_W    (OUT_W),
        .SHIFT    (SHIFT)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_ready (pair_ready),
        .pair_even  (pair_even),
        .pair_odd   (pair_odd),
        .y_even     (y_even),
        .y_odd      (y_odd),
        .y_valid    (y_valid)
    );

    // R7: every pair handed to the core produces a valid strobe one cycle later
    p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |=> y_valid);
endmodule

// File: tb/tb_fir2_unfolded_top.sv
module tb_fir2_unfolded_top;
    localparam int DIV = 3;
    localparam logic [2*8-1:0]  C2  = {8'sd40, 8'sd64};
    localparam logic [4*8-1:0]  C4  = {8'sd18, 8'sd45, 8'sd37, 8'sd12};
    localparam logic [11*8-1:0] C11 = {8'sd1, -8'sd3, 8'sd7, 8'sd19, 8'sd36, 8'sd41,
                                       8'sd34, 8'sd21, 8'sd9, -8'sd4, 8'sd2};
    localparam int TOTAL = 700;
    localparam int RST_AT = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [7:0] din = '0;
    logic tick [3];
    logic vld [3];
    logic signed [15:0] ye [3];
    logic signed [15:0] yo [3];
    logic signed [15:0] last_e [3];
    logic signed [15:0] last_o [3];

    int checks = 0, fails = 0;
    int xs [0:1023];
    int n = 0, p = 0, g = 0;
    longint cyc = 0, exp_cyc = -1, last_tick = -1;
    bit pend = 0, done = 0, did_rst = 0;

    always #2 clk = ~clk;

    fir2_unfolded_top #(.NTAPS(2), .COEFS(C2), .FAST_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .sample_in(din), .slot_tick(tick[0]),
        .y_even(ye[0]), .y_odd(yo[0]), .y_valid(vld[0]));
    fir2_unfolded_top #(.NTAPS(4), .COEFS(C4), .FAST_DIV(DIV)) dut4 (
        .clk(clk), .rst_n(rst_n), .sample_in(din), .slot_tick(tick[1]),
        .y_even(ye[1]), .y_odd(yo[1]), .y_valid(vld[1]));
    fir2_unfolded_top #(.NTAPS(11), .COEFS(C11), .FAST_DIV(DIV)) dut11 (
        .clk(clk), .rst_n(rst_n), .sample_in(din), .slot_tick(tick[2]),
        .y_even(ye[2]), .y_odd(yo[2]), .y_valid(vld[2]));

    function automatic int ntaps(int d);
        return (d == 0) ? 2 : (d == 1) ? 4 : 11;
    endfunction

    function automatic int coef(int d, int j);
        logic signed [7:0] c;
        if (d == 0)      c = C2[j*8 +: 8];
        else if (d == 1) c = C4[j*8 +: 8];
        else             c = C11[j*8 +: 8];
        return int'(c);
    endfunction

    function automatic logic signed [15:0] ref_y(int d, int idx);
        longint acc = 0;
        for (int j = 0; j < ntaps(d); j++)
            if (idx - j >= 0) acc += longint'(coef(d, j)) * longint'(xs[idx-j]);
        acc = acc >>> 4;
        return acc[15:0];
    endfunction

    function automatic logic signed [7:0] stim(int k);
        int v;
        if (k < 20)       v = (k == 3 || k == 10) ? 100 : 0;
        else if (k < 60)  v = 127;
        else if (k < 100) v = -128;
        else if (k < 140) v = (k % 2) ? 127 : -128;
        else if (k < 396) v = k - 268;
        else              v = ((k * 73 + 17) % 256) - 128;
        return v[7:0];
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_reset_state();
        for (int d = 0; d < 3; d++) begin
            check(vld[d] == 1'b0 && tick[d] == 1'b0, "R9 strobes low in reset",
                  {vld[d], tick[d]}, 0);
            check(ye[d] == 0 && yo[d] == 0, "R9 outputs cleared in reset", ye[d] | yo[d], 0);
            last_e[d] = 0;
            last_o[d] = 0;
        end
    endtask

    initial begin
        din = stim(0);
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        while (g < TOTAL) begin
            @(negedge clk);
            cyc++;
            // output side: R4, R5, R6, R7, R8
            for (int d = 0; d < 3; d++) begin
                if (vld[d]) begin
                    check(cyc == exp_cyc, "R7 valid timing", cyc, exp_cyc);
                    check(ye[d] == ref_y(d, 2*p), "R4/R5/R6 even output", ye[d], ref_y(d, 2*p));
                    check(yo[d] == ref_y(d, 2*p+1), "R4/R5/R6 odd output", yo[d], ref_y(d, 2*p+1));
                end else begin
                    check(cyc != exp_cyc, "R7 missing valid", 0, 1);
                    check(ye[d] == last_e[d] && yo[d] == last_o[d], "R8 hold without valid",
                          ye[d], last_e[d]);
                end
                last_e[d] = ye[d];
                last_o[d] = yo[d];
            end
            if (vld[0]) p++;
            // input side: R1, R2, R3
            if (tick[0]) begin
                check(tick[1] && tick[2], "R1 strobes agree", {tick[1], tick[2]}, 3);
                if (last_tick >= 0) check(cyc - last_tick == DIV, "R1 slot spacing",
                                          cyc - last_tick, DIV);
                last_tick = cyc;
                xs[n] = int'(din);
                if (n % 2 == 1) exp_cyc = cyc + 2;
                n++;
                pend = 1;
            end else if (pend) begin
                g++;
                din = stim(g);
                pend = 0;
                if (g == RST_AT && !did_rst) begin
                    did_rst = 1;
                    rst_n = 1'b0;
                    repeat (2) @(negedge clk);
                    check_reset_state();
                    rst_n = 1'b1;
                    n = 0; p = 0; exp_cyc = -1; last_tick = -1; cyc = 0;
                end
            end
        end
        check(p > 50, "R2 pairs produced after reset", p, 51);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule